// File: doc/BRIEF.md
# Supervisor External Interrupt Pending Control

This block holds the machine-level state behind bit 9 of three interrupt control registers: the interrupt-pending register, the virtual-pending register and the virtual-enable register. It merges a live supervisor external interrupt line with one software-writable storage bit. The virtual-enable bit decides whether that storage bit feeds the pending bit, and whether software can write the pending bit at all.

Software writes through a single CSR write port, which carries an address, a data word and a write enable. Each register has its own combinational read port. A pending output drives the trap logic, and it always matches what a software read of the pending bit returns. Nothing is held beyond the OR of the live line and the storage bit.

Top module: `seip_pend_ctrl`

## Requirements
- R1: While the virtual-enable bit is 0, pending bit 9 reads as the incoming interrupt line ORed with the software-writable storage bit.
- R2: Virtual-pending bit 9 always reads the software-writable storage bit. It never reflects the incoming interrupt line.
- R3: While the virtual-enable bit is 1, pending bit 9 reads as the incoming interrupt line alone, and the storage bit has no influence on it.
- R4: `seip_o` equals pending bit 9 on every cycle. Both follow a change on `sei_i` in the same cycle, without waiting for a clock edge.
- R5: A write to the virtual-pending address loads data bit 9 into the storage bit, whatever the virtual-enable setting. A write to the virtual-enable address loads data bit 9 into the virtual-enable bit.
- R6: A write to the pending address loads data bit 9 into the storage bit only while the virtual-enable bit is 0. While it is 1, the write has no effect, which shows on the virtual-pending read port.
- R7: After reset, the storage bit and the virtual-enable bit are both 0.
- R8: Every bit other than bit 9 reads 0 on all three read ports. Writes to those bits are discarded, and writes to any other address change nothing.
- R9: During the cycle in which a register is written, its read port still shows the old value. The new value appears from the next cycle.
- R10: Take this sequence: set virtual-pending to 1; set virtual-enable to 1 with the line high; write virtual-pending to 0; drop the line; clear virtual-enable. At the end, pending bit 9 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sei_i | input | 1 | Incoming supervisor external interrupt line |
| wr_en_i | input | 1 | CSR write enable |
| wr_addr_i | input | ADDR_W | CSR write address |
| wr_data_i | input | XLEN | CSR write data |
| pend_rdata_o | output | XLEN | Pending register read value |
| vpend_rdata_o | output | XLEN | Virtual-pending register read value |
| ven_rdata_o | output | XLEN | Virtual-enable register read value |
| seip_o | output | 1 | Pending bit as seen by the trap logic |

## Verification
On every cycle, the assertions check three things: the OR and select rule for pending bit 9 under both virtual-enable settings, that the unimplemented bits stay at zero, and that the storage bit is loaded, held or ignored correctly after each write. Some behaviours only the bench scenarios can show, because they span many cycles and depend on order. These are the alias sequence that must end at 0, the old value read back during a write cycle, and the same-cycle response of the output to the interrupt line.

// File: rtl/seip_pkg.sv
package seip_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_PEND  = 2'd1,
    TGT_VPEND = 2'd2,
    TGT_VEN   = 2'd3
  } wr_tgt_e;
endpackage

// File: rtl/seip_wr_decode.sv
module seip_wr_decode
  import seip_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] PEND_ADDR  = 12'h344,
  parameter logic [ADDR_W-1:0] VPEND_ADDR = 12'h309,
  parameter logic [ADDR_W-1:0] VEN_ADDR   = 12'h308
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output wr_tgt_e           tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (wr_en_i) begin
      if (wr_addr_i == PEND_ADDR)       tgt_o = TGT_PEND;
      else if (wr_addr_i == VPEND_ADDR) tgt_o = TGT_VPEND;
      else if (wr_addr_i == VEN_ADDR)   tgt_o = TGT_VEN;
    end
  end
endmodule

// File: rtl/seip_state.sv
module seip_state
  import seip_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_tgt_e tgt_i,
  input  logic    wbit_i,
  output logic    sw_seip_o,
  output logic    ven_o
);
  logic sw_q, ven_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      ven_q <= 1'b0;
    end else begin
      case (tgt_i)
        TGT_VPEND: sw_q <= wbit_i;
        TGT_PEND:  if (!ven_q) sw_q <= wbit_i;  // read-only while virtual-enable set
        TGT_VEN:   ven_q <= wbit_i;
        default: ;
      endcase
    end
  end

  assign sw_seip_o = sw_q;
  assign ven_o     = ven_q;

  // R5
  vpend_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == TGT_VPEND) |=> (sw_q == $past(wbit_i)));

  // R6
  pend_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == TGT_PEND && ven_q) |=> $stable(sw_q));

  // R6
  pend_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == TGT_PEND && !ven_q) |=> (sw_q == $past(wbit_i)));

  // R5
  ven_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == TGT_VEN) |=> (ven_q == $past(wbit_i)));
endmodule

// File: rtl/seip_read.sv
module seip_read #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned SEI_IDX = 9
) (
  input  logic            sei_i,
  input  logic            sw_seip_i,
  input  logic            ven_i,
  output logic [XLEN-1:0] pend_o,
  output logic [XLEN-1:0] vpend_o,
  output logic [XLEN-1:0] ven_o,
  output logic            seip_o
);
  logic seip;

  always_comb begin
    seip    = ven_i ? sei_i : (sei_i | sw_seip_i);
    pend_o  = '0;
    vpend_o = '0;
    ven_o   = '0;
    pend_o[SEI_IDX]  = seip;
    vpend_o[SEI_IDX] = sw_seip_i;
    ven_o[SEI_IDX]   = ven_i;
  end

  assign seip_o = seip;  // implicit read equals explicit read
endmodule

// File: rtl/seip_pend_ctrl.sv
module seip_pend_ctrl
  import seip_pkg::*;
#(
  parameter int unsigned       XLEN       = 64,
  parameter int unsigned       ADDR_W     = 12,
  parameter int unsigned       SEI_IDX    = 9,
  parameter logic [ADDR_W-1:0] PEND_ADDR  = 12'h344,
  parameter logic [ADDR_W-1:0] VPEND_ADDR = 12'h309,
  parameter logic [ADDR_W-1:0] VEN_ADDR   = 12'h308
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sei_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   pend_rdata_o,
  output logic [XLEN-1:0]   vpend_rdata_o,
  output logic [XLEN-1:0]   ven_rdata_o,
  output logic              seip_o
);
  localparam logic [XLEN-1:0] IMPL_MASK = XLEN'(1) << SEI_IDX;

  wr_tgt_e tgt;
  logic    sw_seip, ven;

  seip_wr_decode #(
    .ADDR_W(ADDR_W), .PEND_ADDR(PEND_ADDR),
    .VPEND_ADDR(VPEND_ADDR), .VEN_ADDR(VEN_ADDR)
  ) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .tgt_o    (tgt)
  );

  seip_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt),
    .wbit_i   (wr_data_i[SEI_IDX]),
    .sw_seip_o(sw_seip),
    .ven_o    (ven)
  );

  seip_read #(.XLEN(XLEN), .SEI_IDX(SEI_IDX)) u_read (
    .sei_i    (sei_i),
    .sw_seip_i(sw_seip),
    .ven_i    (ven),
    .pend_o   (pend_rdata_o),
    .vpend_o  (vpend_rdata_o),
    .ven_o    (ven_rdata_o),
    .seip_o   (seip_o)
  );

  // R1
  or_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ven_rdata_o[SEI_IDX] |-> (seip_o == (sei_i | vpend_rdata_o[SEI_IDX])));

  // R3
  line_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ven_rdata_o[SEI_IDX] |-> (seip_o == sei_i));

  // R4
  implicit_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seip_o == pend_rdata_o[SEI_IDX]);

  // R8
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_rdata_o | vpend_rdata_o | ven_rdata_o) & ~IMPL_MASK) == '0);

  // R2
  vpend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || (wr_addr_i != VPEND_ADDR && wr_addr_i != PEND_ADDR)) |=> $stable(vpend_rdata_o));
endmodule

// File: tb/seip_pend_ctrl_bench.sv
`timescale 1ns/1ps
module seip_pend_ctrl_bench;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned SEI_IDX = 9;
  localparam logic [ADDR_W-1:0] A_PEND  = 12'h344;
  localparam logic [ADDR_W-1:0] A_VPEND = 12'h309;
  localparam logic [ADDR_W-1:0] A_VEN   = 12'h308;
  localparam logic [ADDR_W-1:0] A_OTHER = 12'h123;
  localparam int NVEC = 15;
  // {wen, sel[1:0] (0 pend,1 vpend,2 ven,3 other), d9, sei, exp_pend, exp_vpend, exp_ven}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1_01_1_0_110,  // R5 vpend=1, R1 OR via storage
    8'b0_00_0_1_110,  // R2 line high, vpend stays
    8'b1_01_0_1_100,  // R1 line alone, storage 0
    8'b0_00_0_0_000,
    8'b1_00_1_0_110,  // R6 pend write while ven=0
    8'b1_10_1_0_011,  // R3 ven=1 masks storage
    8'b1_00_0_0_011,  // R6 pend write ignored
    8'b0_00_0_1_111,  // R3 line only
    8'b1_01_0_1_101,  // R5 vpend write while ven=1
    8'b1_10_0_0_000,
    8'b1_11_1_0_000,  // R8 other address ignored
    8'b1_01_1_0_110,
    8'b1_10_1_0_011,
    8'b1_00_0_0_011,  // R6 ignored again
    8'b1_10_0_0_110   // R1 storage reappears
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sei = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [XLEN-1:0] pend_rd, vpend_rd, ven_rd;
  logic seip;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  seip_pend_ctrl u_seip_pend_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sei_i(sei),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pend_rdata_o(pend_rd), .vpend_rdata_o(vpend_rd),
    .ven_rdata_o(ven_rd), .seip_o(seip)
  );

  function automatic logic [XLEN-1:0] word(input logic b);
    word = XLEN'(b) << SEI_IDX;
  endfunction

  function automatic logic [XLEN-1:0] wdata(input logic b);
    wdata = ~(XLEN'(1) << SEI_IDX) | word(b);  // all other bits set
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic ep, input logic evp, input logic eve);
    check({req, " pend"}, pend_rd, word(ep));
    check({req, " vpend"}, vpend_rd, word(evp));
    check({req, " ven"}, ven_rd, word(eve));
    check({req, " R4 seip"}, XLEN'(seip), XLEN'(ep));
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = wdata(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; sei = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_all("R7 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [ADDR_W-1:0] a;
      @(negedge clk);
      case (VEC[i][6:5])
        2'd0: a = A_PEND;
        2'd1: a = A_VPEND;
        2'd2: a = A_VEN;
        default: a = A_OTHER;
      endcase
      wr_en = VEC[i][7]; wr_addr = a; wr_data = wdata(VEC[i][4]); sei = VEC[i][3];
      @(negedge clk);
      wr_en = 1'b0;
      check_all($sformatf("R8 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R10 alias sequence
    do_reset();
    wr(A_VPEND, 1'b1);
    sei = 1'b1;
    wr(A_VEN, 1'b1);
    wr(A_VPEND, 1'b0);
    check_all("R10 mid", 1'b1, 1'b0, 1'b1);
    sei = 1'b0;
    wr(A_VEN, 1'b0);
    check_all("R10 end", 1'b0, 1'b0, 1'b0);

    // R9 old value during write cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_VPEND; wr_data = wdata(1'b1);
    #1 check("R9 old vpend", vpend_rd, word(1'b0));
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 new vpend", vpend_rd, word(1'b1));

    // R4 same-cycle response to line, ven=1
    wr(A_VEN, 1'b1);
    @(posedge clk); #2;
    sei = 1'b1;
    #1 check("R4 rise", XLEN'(seip), XLEN'(1'b1));
    sei = 1'b0;
    #1 check("R4 fall", XLEN'(seip), XLEN'(1'b0));

    // R7 reset clears state set above
    do_reset();
    check_all("R7 re-reset", 1'b0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule